// File: doc/BRIEF.md
# Edge-Capture Timer

A free-running up-counter shared by several capture channels. Each channel watches one external pin. The pin passes through a synchronizer, and the channel then looks for edges on the synchronized signal. When an edge of the chosen kind arrives, the channel stores the counter value of that cycle, sets its capture flag and, if its interrupt enable is set, drives the combined interrupt line. Software can also force a capture by writing to an event register. Software finds pulse widths and periods by subtracting stored counter values.

Software reaches the block over a simple register bus with read and write strobes. Capture flags clear only when a 0 is written to them. A 1 written to a flag leaves it as it is. Reading a capture register also clears that channel's flag. If a capture arrives while the flag is still set, the channel sets an overcapture bit, which clears only when a 0 is written to it.

Top module: `cap_timer_unit`

## Requirements
- R1: The counter is at address 6 and CTRL (address 0) bit 0 is the run bit. The counter advances by exactly one per clock while the run bit is set and holds its value while the run bit is clear.
- R2: The counter is 16 bits wide and wraps from 0xFFFF to 0x0000. A write to address 6 loads it, and the load takes priority over the increment.
- R3: A pin edge causes a capture only when the channel's mode field is 01 and its enable bit is set. Channel i's mode field is MODE (address 1) bits [2i+1:2i]. Its enable bit is ARM (address 2) bit 3i.
- R4: ARM bit 3i+1 (P) and bit 3i+2 (NP) choose the active edge. P=0,NP=0 selects rising. P=1,NP=0 selects falling. P=1,NP=1 selects both edges. P=0,NP=1 selects rising.
- R5: A capture stores the counter value of the cycle in which the edge is detected. With the two-stage synchronizer and the counter running, the stored value is the count visible when the pin changed, plus 2.
- R6: STATUS (address 4) holds capture flag i at bit i and overcapture i at bit 4+i. Writing a bit as 0 clears it. Writing it as 1 leaves it unchanged.
- R7: Reading channel i's capture register (address 8+i) returns the stored value and clears flag i. The read leaves overcapture i unchanged.
- R8: A capture that arrives while flag i is set sets overcapture i. Overcapture i clears only when a 0 is written to it.
- R9: Writing 1 to bit i of EVENT (address 5) forces a capture on channel i when its mode field is 01. The forced capture stores the counter and sets the flag. EVENT always reads as 0.
- R10: irq_o is high while any channel has both its flag set and its bit set in IRQEN (address 3).
- R11: After reset, all registers, capture values and flags read as zero and irq_o is low.
- R12: When a capture and a clear of the same flag fall in the same cycle, the capture wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin_i | input | NUM_CH | External capture pins, asynchronous |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rd_i | input | 1 | Read strobe; a read of a capture register clears that channel's flag |
| bus_rdata_o | output | DATA_W | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Combined capture interrupt |

## Verification
A table of edge vectors drives rising and falling transitions on every channel against each of the four polarity codes. A missed edge and a wrongly accepted edge therefore show up as separate flag results, and the value stored is compared with a stopped counter. A transition made while the counter runs separates the correct two-cycle synchronizer offset from an off-by-one. A write of all ones followed by a write of zeros separates the write-0-clears rule from write-1-clears. Back-to-back forced events, a clear issued in the very cycle of a capture, and an edge on a channel not in input mode probe overcapture, collision priority and gating.

// File: rtl/cap_pkg.sv
package cap_pkg;

   // register addresses
   localparam int unsigned A_CTRL  = 0;
   localparam int unsigned A_MODE  = 1;
   localparam int unsigned A_ARM   = 2;
   localparam int unsigned A_IEN   = 3;
   localparam int unsigned A_STAT  = 4;
   localparam int unsigned A_EVT   = 5;
   localparam int unsigned A_CNT   = 6;
   localparam int unsigned A_CAP0  = 8;

   localparam logic [1:0] MODE_INPUT = 2'b01;
   localparam int unsigned ARM_BITS  = 3;

   // active-edge decode: {np,p}
   function automatic logic edge_hit(input logic p, input logic np,
                                     input logic rise, input logic fall);
      logic hit;
      case ({np, p})
         2'b01:   hit = fall;
         2'b11:   hit = rise | fall;
         default: hit = rise;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   // STAGES synchronizer flops plus one history flop
   logic [STAGES:0] shft_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shft_q <= '0;
      else        shft_q <= {shft_q[STAGES-1:0], pin_i};
   end

   assign rise_o =  shft_q[STAGES-1] & ~shft_q[STAGES];
   assign fall_o = ~shft_q[STAGES-1] &  shft_q[STAGES];
endmodule

// File: rtl/cap_counter.sv
module cap_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hw_evt_i,
   input  logic         sw_evt_i,
   input  logic [W-1:0] cnt_i,
   input  logic         rd_clr_i,
   input  logic         st_wr_i,
   input  logic         st_flag_bit_i,
   input  logic         st_ovr_bit_i,
   output logic [W-1:0] cap_o,
   output logic         flag_o,
   output logic         ovr_o,
   output logic         evt_o
);
   logic [W-1:0] cap_q;
   logic         flag_q;
   logic         ovr_q;
   logic         evt;

   assign evt = hw_evt_i | sw_evt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q  <= '0;
         flag_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else begin
         if (evt) cap_q <= cnt_i;
         // a capture outranks any clear in the same cycle
         if (evt)                           flag_q <= 1'b1;
         else if (rd_clr_i)                 flag_q <= 1'b0;
         else if (st_wr_i && !st_flag_bit_i) flag_q <= 1'b0;
         if (evt && flag_q)                 ovr_q <= 1'b1;
         else if (st_wr_i && !st_ovr_bit_i) ovr_q <= 1'b0;
      end
   end

   assign cap_o  = cap_q;
   assign flag_o = flag_q;
   assign ovr_o  = ovr_q;
   assign evt_o  = evt;
endmodule

// File: rtl/cap_timer_unit.sv
module cap_timer_unit
   import cap_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] cap_pin_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic              bus_wr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_rd_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   localparam int unsigned MODE_W = 2 * NUM_CH;
   localparam int unsigned ARM_W  = ARM_BITS * NUM_CH;
   localparam int unsigned STAT_W = 2 * NUM_CH;

   localparam logic [ADDR_W-1:0] AD_CTRL = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
   localparam logic [ADDR_W-1:0] AD_ARM  = ADDR_W'(A_ARM);
   localparam logic [ADDR_W-1:0] AD_IEN  = ADDR_W'(A_IEN);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] AD_EVT  = ADDR_W'(A_EVT);
   localparam logic [ADDR_W-1:0] AD_CNT  = ADDR_W'(A_CNT);

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_chk_ch
      initial $fatal(1, "NUM_CH must be at least 1");
   end
   if (ARM_W > DATA_W || STAT_W > DATA_W || CNT_W > DATA_W) begin : g_chk_w
      initial $fatal(1, "DATA_W too narrow for the register fields");
   end
   if (A_CAP0 + NUM_CH > (1 << ADDR_W)) begin : g_chk_a
      initial $fatal(1, "ADDR_W too narrow for the capture registers");
   end
   if (SYNC_STAGES < 2) begin : g_chk_s
      initial $fatal(1, "SYNC_STAGES must be at least 2");
   end

   logic                         run_q;
   logic [MODE_W-1:0]            mode_q;
   logic [ARM_W-1:0]             arm_q;
   logic [NUM_CH-1:0]            ien_q;
   logic [CNT_W-1:0]             cnt_q;
   logic [NUM_CH-1:0]            flag;
   logic [NUM_CH-1:0]            ovr;
   logic [NUM_CH-1:0]            evt;
   logic [NUM_CH-1:0][CNT_W-1:0] cap_val;
   logic                         st_wr;
   logic [DATA_W-1:0]            rdata_c;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         mode_q <= '0;
         arm_q  <= '0;
         ien_q  <= '0;
      end else if (bus_wr_i) begin
         case (bus_addr_i)
            AD_CTRL: run_q  <= bus_wdata_i[0];
            AD_MODE: mode_q <= bus_wdata_i[MODE_W-1:0];
            AD_ARM:  arm_q  <= bus_wdata_i[ARM_W-1:0];
            AD_IEN:  ien_q  <= bus_wdata_i[NUM_CH-1:0];
            default: ;
         endcase
      end
   end

   cap_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (run_q),
      .load_i    (bus_wr_i && bus_addr_i == AD_CNT),
      .load_val_i(bus_wdata_i[CNT_W-1:0]),
      .cnt_o     (cnt_q)
   );

   assign st_wr = bus_wr_i && bus_addr_i == AD_STAT;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic rise;
      logic fall;
      logic is_input;
      logic hw_evt;
      logic sw_evt;
      logic rd_clr;

      cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .pin_i (cap_pin_i[i]),
         .rise_o(rise),
         .fall_o(fall)
      );

      assign is_input = mode_q[2*i +: 2] == MODE_INPUT;
      assign hw_evt   = is_input && arm_q[ARM_BITS*i] &&
                        edge_hit(arm_q[ARM_BITS*i+1], arm_q[ARM_BITS*i+2], rise, fall);
      assign sw_evt   = is_input && bus_wr_i && bus_addr_i == AD_EVT && bus_wdata_i[i];
      assign rd_clr   = bus_rd_i && bus_addr_i == ADDR_W'(A_CAP0 + i);

      cap_channel #(.W(CNT_W)) u_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .hw_evt_i     (hw_evt),
         .sw_evt_i     (sw_evt),
         .cnt_i        (cnt_q),
         .rd_clr_i     (rd_clr),
         .st_wr_i      (st_wr),
         .st_flag_bit_i(bus_wdata_i[i]),
         .st_ovr_bit_i (bus_wdata_i[NUM_CH+i]),
         .cap_o        (cap_val[i]),
         .flag_o       (flag[i]),
         .ovr_o        (ovr[i]),
         .evt_o        (evt[i])
      );
   end

   // read mux; the event register has no storage and returns zero
   always_comb begin
      rdata_c = '0;
      if (bus_rd_i) begin
         case (bus_addr_i)
            AD_CTRL: rdata_c[0]            = run_q;
            AD_MODE: rdata_c[MODE_W-1:0]   = mode_q;
            AD_ARM:  rdata_c[ARM_W-1:0]    = arm_q;
            AD_IEN:  rdata_c[NUM_CH-1:0]   = ien_q;
            AD_STAT: rdata_c[STAT_W-1:0]   = {ovr, flag};
            AD_CNT:  rdata_c[CNT_W-1:0]    = cnt_q;
            default: ;
         endcase
         for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr_i == ADDR_W'(A_CAP0 + i)) rdata_c[CNT_W-1:0] = cap_val[i];
         end
      end
   end

   assign bus_rdata_o = rdata_c;
   assign irq_o       = |(flag & ien_q);
endmodule

// File: rtl/cap_timer_unit_chk.sv
module cap_timer_unit_chk
   import cap_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic                irq,
   input logic                run,
   input logic [CNT_W-1:0]    cnt,
   input logic [2*NUM_CH-1:0] mode,
   input logic [NUM_CH-1:0]   flag,
   input logic [NUM_CH-1:0]   ovr,
   input logic [NUM_CH-1:0]   evt
);
   localparam logic [ADDR_W-1:0] K_STAT = ADDR_W'(A_STAT);
   localparam logic [ADDR_W-1:0] K_EVT  = ADDR_W'(A_EVT);
   localparam logic [ADDR_W-1:0] K_CNT  = ADDR_W'(A_CNT);

   logic cnt_wr;
   assign cnt_wr = bus_wr && bus_addr == K_CNT;

   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> cnt == $past(cnt));                          // R1
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !cnt_wr) |=> cnt == CNT_W'($past(cnt) + 1'b1));            // R2
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt == $past(bus_wdata[CNT_W-1:0]));                    // R2
   AST_EVT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == K_EVT) |-> bus_rdata == '0);                // R9
   AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag != '0);                                               // R10

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      AST_ONE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[i] && bus_wr && bus_addr == K_STAT && bus_wdata[i]) |=> flag[i]);        // R6
      AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == ADDR_W'(A_CAP0 + i) && !evt[i]) |=> !flag[i]);          // R7
      AST_OVR_ON_SET_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && flag[i]) |=> ovr[i]);                                               // R8
      AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == K_EVT && bus_wdata[i] && mode[2*i +: 2] == MODE_INPUT)
         |=> flag[i]);                                                                  // R9
      AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> flag[i]);                                                           // R12
   end
endmodule

bind cap_timer_unit cap_timer_unit_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_addr (bus_addr_i),
   .bus_wr   (bus_wr_i),
   .bus_wdata(bus_wdata_i),
   .bus_rd   (bus_rd_i),
   .bus_rdata(bus_rdata_o),
   .irq      (irq_o),
   .run      (run_q),
   .cnt      (cnt_q),
   .mode     (mode_q),
   .flag     (flag),
   .ovr      (ovr),
   .evt      (evt)
);

// File: tb/cap_timer_unit_tb_top.sv
module cap_timer_unit_tb_top;
   localparam int NCH = 4;
   localparam logic [3:0] AD_CTRL = 4'd0, AD_MODE = 4'd1, AD_ARM = 4'd2, AD_IEN = 4'd3,
                          AD_STAT = 4'd4, AD_EVT = 4'd5, AD_CNT = 4'd6, AD_CAP0 = 4'd8;
   localparam logic [15:0] CNT_FIX = 16'h1234;

   // vector: {channel[1:0], np, p, rising, expect_capture}
   localparam logic [5:0] VEC [8] = '{
      6'b00_00_1_1, 6'b00_00_0_0,
      6'b01_01_0_1, 6'b01_01_1_0,
      6'b10_11_1_1, 6'b10_11_0_1,
      6'b11_10_1_1, 6'b11_10_0_0
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  pins = '0;
   logic [3:0]      addr = '0;
   logic            wr = 1'b0;
   logic [15:0]     wdata = '0;
   logic            rd = 1'b0;
   logic [15:0]     rdata;
   logic            irq;
   int              total = 0;
   int              bad = 0;

   always #5 clk = ~clk;

   cap_timer_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_pin_i  (pins),
      .bus_addr_i (addr),
      .bus_wr_i   (wr),
      .bus_wdata_i(wdata),
      .bus_rd_i   (rd),
      .bus_rdata_o(rdata),
      .irq_o      (irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 v = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
   end

   initial begin
      logic [15:0] v, a, b, c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R11: reset state
      rd_reg(AD_CTRL, v); check("R11 ctrl", v, 16'h0);
      rd_reg(AD_STAT, v); check("R11 status", v, 16'h0);
      rd_reg(AD_CAP0, v); check("R11 cap0", v, 16'h0);
      #1 check("R11 irq", {15'h0, irq}, 16'h0);
      rd_reg(AD_CNT, a);  check("R11 count", a, 16'h0);
      repeat (5) @(negedge clk);
      rd_reg(AD_CNT, b);  check("R1 stopped hold", b, a);

      // edge-vector table, counter stopped at a fixed value
      wr_reg(AD_CNT, CNT_FIX);
      wr_reg(AD_MODE, 16'h0055);
      for (int k = 0; k < 8; k++) begin
         int ch;
         logic np, p, rise, expc;
         ch = int'(VEC[k][5:4]);
         {np, p, rise, expc} = VEC[k][3:0];
         wr_reg(AD_ARM, 16'h0);
         pins[ch] = ~rise;
         repeat (4) @(negedge clk);
         wr_reg(AD_STAT, 16'h0);
         wr_reg(AD_ARM, 16'({np, p, 1'b1}) << (3 * ch));
         pins[ch] = rise;
         repeat (5) @(negedge clk);
         rd_reg(AD_STAT, v);
         check($sformatf("R4 vec%0d flag", k), {15'h0, v[ch]}, {15'h0, expc});
         if (expc) begin
            rd_reg(AD_CAP0 + 4'(ch), v);
            check($sformatf("R3 vec%0d value", k), v, CNT_FIX);
         end
         wr_reg(AD_STAT, 16'h0);
      end

      // R1: running counter advances one per clock
      wr_reg(AD_CNT, 16'h0100);
      wr_reg(AD_CTRL, 16'h1);
      rd_reg(AD_CNT, a);
      repeat (10) @(negedge clk);
      rd_reg(AD_CNT, b);
      check("R1 step", b, a + 16'd12);

      // R2: wrap through 0xFFFF while loaded during run
      wr_reg(AD_CNT, 16'hFFF8);
      rd_reg(AD_CNT, a);
      check("R2 load", a, 16'hFFF9);
      repeat (10) @(negedge clk);
      rd_reg(AD_CNT, b);
      check("R2 wrap", b, 16'h0005);

      // R5: capture while running, both edges on channel 0
      wr_reg(AD_ARM, 16'h0007);
      wr_reg(AD_STAT, 16'h0);
      @(negedge clk);
      addr = AD_CNT; rd = 1'b1; pins[0] = ~pins[0];
      #1 c0 = rdata;
      @(negedge clk);
      rd = 1'b0;
      repeat (4) @(negedge clk);
      // R6: writing ones clears nothing
      wr_reg(AD_STAT, 16'hFFFF);
      rd_reg(AD_STAT, v);
      check("R6 flag kept", {15'h0, v[0]}, 16'h1);
      rd_reg(AD_CAP0, v);
      check("R5 running capture", v, c0 + 16'd2);
      rd_reg(AD_STAT, v);
      check("R7 read clears", {15'h0, v[0]}, 16'h0);

      // R12: status clear lands in the capture cycle
      @(negedge clk);
      pins[0] = ~pins[0];
      @(negedge clk);
      wr_reg(AD_STAT, 16'h0);
      rd_reg(AD_STAT, v);
      check("R12 capture wins", {15'h0, v[0]}, 16'h1);
      check("R12 no overcapture", {15'h0, v[4]}, 16'h0);
      wr_reg(AD_STAT, 16'h0);

      // R9 / R10: forced capture and interrupt gating
      wr_reg(AD_CTRL, 16'h0);
      wr_reg(AD_CNT, 16'h0AB0);
      wr_reg(AD_EVT, 16'h0002);
      #1 check("R10 irq masked", {15'h0, irq}, 16'h0);
      rd_reg(AD_CAP1_addr(), v);
      check("R9 forced value", v, 16'h0AB0);
      wr_reg(AD_EVT, 16'h0002);
      wr_reg(AD_IEN, 16'h0002);
      #1 check("R10 irq raised", {15'h0, irq}, 16'h1);
      rd_reg(AD_EVT, v);
      check("R9 event reads zero", v, 16'h0);
      wr_reg(AD_STAT, 16'h0);
      #1 check("R10 irq dropped", {15'h0, irq}, 16'h0);

      // R8: overcapture
      wr_reg(AD_EVT, 16'h0004);
      wr_reg(AD_EVT, 16'h0004);
      rd_reg(AD_STAT, v);
      check("R8 ovr set", {15'h0, v[6]}, 16'h1);
      rd_reg(AD_CAP0 + 4'd2, v);
      rd_reg(AD_STAT, v);
      check("R8 ovr survives read", {14'h0, v[6], v[2]}, 16'h2);
      wr_reg(AD_STAT, 16'hFFFF);
      rd_reg(AD_STAT, v);
      check("R8 ovr kept by ones", {15'h0, v[6]}, 16'h1);
      wr_reg(AD_STAT, 16'h0);
      rd_reg(AD_STAT, v);
      check("R8 ovr cleared by zero", {15'h0, v[6]}, 16'h0);

      // R3: channel not in input mode ignores edges and forced events
      wr_reg(AD_MODE, 16'h0015);
      wr_reg(AD_ARM, 16'h0200);
      pins[3] = 1'b0;
      repeat (4) @(negedge clk);
      pins[3] = 1'b1;
      repeat (5) @(negedge clk);
      rd_reg(AD_STAT, v);
      check("R3 mode gate edge", {15'h0, v[3]}, 16'h0);
      wr_reg(AD_EVT, 16'h0008);
      rd_reg(AD_STAT, v);
      check("R9 mode gate force", {15'h0, v[3]}, 16'h0);

      finish_run();
   end

   function automatic logic [3:0] AD_CAP1_addr();
      return AD_CAP0 + 4'd1;
   endfunction
endmodule